// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Condition Flags

This block is the arithmetic slice of a 32-bit load/store integer datapath. It adds or subtracts two operands and returns the result for the destination register. The first operand always comes from a register read port. The second operand is either another register value or a small signed constant carried in the instruction word. The constant is sign-extended to the data width before it is used. Neither source value is altered by the unit.

A four-bit condition register sits beside the arithmetic path. It is written only when the instruction is the flag-setting form of add or subtract and the unit is enabled in that cycle. In every other cycle it keeps its contents, so a later conditional branch still sees the flags left by the last flag-setting instruction. Ordinary add and subtract pass through without touching it.

The result is combinational from the inputs. The flags become visible one clock edge after the flag-setting operation is presented. Every input and output is a plain signal; the unit has no handshake because it accepts one operation per cycle and never stalls.

Top module: `int_alu_cc`

## Requirements
- R1: With op_sub = 0, result equals rs1_data plus the second operand, modulo 2^DATA_W.
- R2: With op_sub = 1, result equals rs1_data minus the second operand, modulo 2^DATA_W.
- R3: With imm_sel = 1, the second operand is imm_field sign-extended from IMM_W bits (range -2^(IMM_W-1) to 2^(IMM_W-1)-1) and rs2_data has no effect on result or flags; with imm_sel = 0 it is rs2_data.
- R4: After a clock edge where alu_en = 1 and set_cc = 1, cc_flags[2] (zero) is 1 exactly when the result was zero and cc_flags[3] (negative) equals the result's top bit; for an add, cc_flags[0] (carry) is the unsigned carry out of the top bit.
- R5: For a flag-setting subtract, cc_flags[0] is the borrow: 1 exactly when rs1_data is below the second operand as unsigned numbers.
- R6: cc_flags[1] (overflow) is set by an add when both operands share a sign and the result's sign differs, and by a subtract when the operands differ in sign and the result's sign differs from rs1_data.
- R7: At a clock edge where alu_en = 0 or set_cc = 0, cc_flags keeps its value; result is still produced.
- R8: While rst_n is low, cc_flags is 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flag register |
| alu_en | input | 1 | Operation valid in this cycle |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| set_cc | input | 1 | Flag-setting form of the operation |
| imm_sel | input | 1 | 1 = second operand from imm_field, 0 = from rs2_data |
| rs1_data | input | DATA_W | First source operand |
| rs2_data | input | DATA_W | Register form of the second operand |
| imm_field | input | IMM_W | Signed constant form of the second operand |
| result | output | DATA_W | Arithmetic result for the destination |
| cc_flags | output | 4 | Registered flags {negative, zero, overflow, carry} |

## Verification
The bench builds the unit with DATA_W = 8 and IMM_W = 5, which shrinks the operand space enough that every first-operand value is swept against a set of second operands that includes zero, one, both sign boundaries and all-ones, in both add and subtract. At that width every carry, borrow and overflow case, plus a zero result from both operations, occurs within a few thousand cycles. All 32 constant values are swept against a spread of register values with a clashing rs2_data, covering the most negative and most positive constants. Cycles with the enable or the flag-setting bit low follow operations chosen to change every flag, so a hold failure shows at the outputs.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

  // Condition flags, packed so that bit 3 = negative and bit 0 = carry.
  typedef struct packed {
    logic neg;
    logic zero;
    logic ovf;
    logic carry;
  } cc_t;

  typedef enum logic {
    ARITH_ADD = 1'b0,
    ARITH_SUB = 1'b1
  } arith_op_e;

  localparam int unsigned CC_W = $bits(cc_t);

endpackage

// File: rtl/operand_sel.sv
module operand_sel #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 13
) (
  input  logic              imm_sel,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [IMM_W-1:0]  imm_val,
  output logic [DATA_W-1:0] op2
);

  logic [DATA_W-1:0] imm_ext;

  generate
    if (IMM_W < DATA_W) begin : g_extend
      localparam int unsigned PAD_W = DATA_W - IMM_W;
      assign imm_ext = {{PAD_W{imm_val[IMM_W-1]}}, imm_val};
    end else begin : g_trunc
      assign imm_ext = imm_val[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    op2 = imm_sel ? imm_ext : reg_val;
  end

endmodule

// File: rtl/addsub_unit.sv
module addsub_unit #(
  parameter int unsigned DATA_W = 32
) (
  input  alu_cc_pkg::arith_op_e op,
  input  logic [DATA_W-1:0]     a,
  input  logic [DATA_W-1:0]     b,
  output logic [DATA_W-1:0]     sum,
  output logic                  carry_out
);

  localparam int unsigned EXT_W = DATA_W + 1;

  logic [DATA_W-1:0] b_eff;
  logic [EXT_W-1:0]  wide;
  logic              cin;

  always_comb begin
    cin   = (op == alu_cc_pkg::ARITH_SUB);
    b_eff = cin ? ~b : b;
    wide  = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};
    sum       = wide[DATA_W-1:0];
    carry_out = wide[DATA_W];
  end

endmodule

// File: rtl/flag_calc.sv
module flag_calc #(
  parameter int unsigned DATA_W = 32
) (
  input  alu_cc_pkg::arith_op_e op,
  input  logic                  a_msb,
  input  logic                  b_msb,
  input  logic [DATA_W-1:0]     sum,
  input  logic                  carry_out,
  output alu_cc_pkg::cc_t       flags
);

  logic is_sub;
  logic sign_clash;

  always_comb begin
    is_sub     = (op == alu_cc_pkg::ARITH_SUB);
    // Add overflows on like signs, subtract on unlike signs.
    sign_clash = is_sub ? (a_msb != b_msb) : (a_msb == b_msb);
    flags.neg   = sum[DATA_W-1];
    flags.zero  = (sum == '0);
    flags.ovf   = sign_clash && (sum[DATA_W-1] != a_msb);
    // a + ~b + 1 carries out exactly when no borrow occurs.
    flags.carry = is_sub ? ~carry_out : carry_out;
  end

endmodule

// File: rtl/cc_reg.sv
module cc_reg (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  alu_cc_pkg::cc_t d,
  output alu_cc_pkg::cc_t q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load) begin
      q <= d;
    end
  end

endmodule

// File: rtl/int_alu_cc.sv
module int_alu_cc #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alu_en,
  input  logic              op_sub,
  input  logic              set_cc,
  input  logic              imm_sel,
  input  logic [DATA_W-1:0] rs1_data,
  input  logic [DATA_W-1:0] rs2_data,
  input  logic [IMM_W-1:0]  imm_field,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        cc_flags
);

  alu_cc_pkg::arith_op_e op;
  alu_cc_pkg::cc_t       next_cc;
  alu_cc_pkg::cc_t       cur_cc;
  logic [DATA_W-1:0]     op2;
  logic [DATA_W-1:0]     sum;
  logic                  carry_out;
  logic                  cc_load;

  assign op      = op_sub ? alu_cc_pkg::ARITH_SUB : alu_cc_pkg::ARITH_ADD;
  assign cc_load = alu_en & set_cc;

  operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
    .imm_sel (imm_sel),
    .reg_val (rs2_data),
    .imm_val (imm_field),
    .op2     (op2)
  );

  addsub_unit #(.DATA_W(DATA_W)) u_addsub (
    .op        (op),
    .a         (rs1_data),
    .b         (op2),
    .sum       (sum),
    .carry_out (carry_out)
  );

  flag_calc #(.DATA_W(DATA_W)) u_flags (
    .op        (op),
    .a_msb     (rs1_data[DATA_W-1]),
    .b_msb     (op2[DATA_W-1]),
    .sum       (sum),
    .carry_out (carry_out),
    .flags     (next_cc)
  );

  cc_reg u_ccreg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cc_load),
    .d     (next_cc),
    .q     (cur_cc)
  );

  assign result   = sum;
  assign cc_flags = cur_cc;

endmodule

// File: rtl/int_alu_cc_checker.sv
module int_alu_cc_checker #(
  parameter int unsigned W     = 32,
  parameter int unsigned IMM_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alu_en,
  input logic             op_sub,
  input logic             set_cc,
  input logic             imm_sel,
  input logic [W-1:0]     rs1_data,
  input logic [W-1:0]     rs2_data,
  input logic [IMM_W-1:0] imm_field,
  input logic [W-1:0]     result,
  input logic [3:0]       cc_flags
);

  logic [W-1:0] chk_op2;
  logic         wr;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      chk_op2[i] = imm_sel ? imm_field[(i < IMM_W) ? i : IMM_W-1] : rs2_data[i];
    end
    wr = alu_en && set_cc;
  end

  assert_add_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !op_sub |-> result == W'(rs1_data + chk_op2));

  assert_sub_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op_sub |-> result == W'(rs1_data - chk_op2));

  assert_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> cc_flags[2] == ($past(result) == '0));

  assert_neg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> cc_flags[3] == $past(result[W-1]));

  assert_borrow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && op_sub) |=> cc_flags[0] == ($past(rs1_data) < $past(chk_op2)));

  assert_add_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !op_sub) |=> cc_flags[1] ==
      (($past(rs1_data[W-1]) == $past(chk_op2[W-1])) &&
       ($past(result[W-1]) != $past(rs1_data[W-1]))));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(cc_flags));

endmodule

bind int_alu_cc int_alu_cc_checker #(.W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .alu_en    (alu_en),
  .op_sub    (op_sub),
  .set_cc    (set_cc),
  .imm_sel   (imm_sel),
  .rs1_data  (rs1_data),
  .rs2_data  (rs2_data),
  .imm_field (imm_field),
  .result    (result),
  .cc_flags  (cc_flags)
);

// File: tb/int_alu_cc_test.sv
`timescale 1ns/1ps
module int_alu_cc_test;

  localparam int W  = 8;
  localparam int IW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          alu_en = 1'b0;
  logic          op_sub = 1'b0;
  logic          set_cc = 1'b0;
  logic          imm_sel = 1'b0;
  logic [W-1:0]  rs1_data = '0;
  logic [W-1:0]  rs2_data = '0;
  logic [IW-1:0] imm_field = '0;
  logic [W-1:0]  result;
  logic [3:0]    cc_flags;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;
  logic [3:0] model_cc = 4'b0000;

  always #4 clk = ~clk;

  int_alu_cc #(.DATA_W(W), .IMM_W(IW)) uut (
    .clk(clk), .rst_n(rst_n), .alu_en(alu_en), .op_sub(op_sub),
    .set_cc(set_cc), .imm_sel(imm_sel), .rs1_data(rs1_data),
    .rs2_data(rs2_data), .imm_field(imm_field), .result(result),
    .cc_flags(cc_flags)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input bit sub, input logic [W-1:0] a, input logic [W-1:0] r2,
                     input logic [IW-1:0] imm, input bit isel, input bit en, input bit scc);
    int b, r, c, v;
    int sa, sb, sr;
    @(negedge clk);
    op_sub = sub; rs1_data = a; rs2_data = r2; imm_field = imm;
    imm_sel = isel; alu_en = en; set_cc = scc;
    b = isel ? (imm[IW-1] ? (int'(imm) - (1 << IW)) & 8'hff : int'(imm)) : int'(r2);
    if (sub) begin
      r = (int'(a) - b) & 8'hff;
      c = (int'(a) < b) ? 1 : 0;
    end else begin
      r = (int'(a) + b) & 8'hff;
      c = ((int'(a) + b) > 255) ? 1 : 0;
    end
    sa = a[W-1]; sb = (b >> (W-1)) & 1; sr = (r >> (W-1)) & 1;
    v = (sub ? (sa != sb) : (sa == sb)) && (sr != sa);
    #1;
    if (isel) check("R3 result", result, r);
    else if (sub) check("R2 result", result, r);
    else check("R1 result", result, r);
    @(posedge clk); #1;
    if (en && scc) begin
      model_cc = {sr[0], (r == 0), v[0], c[0]};
      check("R4 zero", cc_flags[2], model_cc[2]);
      check("R4 negative", cc_flags[3], model_cc[3]);
      check("R6 overflow", cc_flags[1], model_cc[1]);
      if (sub) check("R5 borrow", cc_flags[0], model_cc[0]);
      else check("R4 carry", cc_flags[0], model_cc[0]);
    end else begin
      check("R7 hold", cc_flags, model_cc);
    end
  endtask

  function automatic logic [W-1:0] pick_b(input int j);
    if (j < 16) return W'(j * 17);
    else if (j == 16) return 8'h7f;
    else if (j == 17) return 8'h80;
    else return 8'h01;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R8 reset flags", cc_flags, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1 check("R8 flags after release", cc_flags, 0);

    // Register-operand sweep, both operations, flag-setting.
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 256; a++)
        for (int j = 0; j < 19; j++)
          run(s[0], W'(a), pick_b(j), '0, 1'b0, 1'b1, 1'b1);

    // Immediate sweep with rs2_data set to a clashing value (R3).
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 256; a += 17)
        for (int k = 0; k < 32; k++)
          run(s[0], W'(a), 8'h5a, IW'(k), 1'b1, 1'b1, 1'b1);

    // R7: set all-distinct flags, then non-writing operations.
    run(1'b1, 8'h00, 8'h01, '0, 1'b0, 1'b1, 1'b1);   // neg, borrow
    run(1'b0, 8'h80, 8'h80, '0, 1'b0, 1'b1, 1'b0);   // plain add
    run(1'b1, 8'h05, 8'h05, '0, 1'b0, 1'b0, 1'b1);   // disabled
    run(1'b0, 8'h7f, 8'h01, '0, 1'b0, 1'b0, 1'b0);
    run(1'b0, 8'h80, 8'h80, '0, 1'b0, 1'b1, 1'b1);   // zero, ovf, carry
    run(1'b1, 8'h10, 8'h01, '0, 1'b0, 1'b1, 1'b0);
    run(1'b0, 8'h01, 8'h02, 5'h1f, 1'b1, 1'b0, 1'b1);

    // R8: reset clears flags set above.
    run(1'b1, 8'h00, 8'h01, '0, 1'b0, 1'b1, 1'b1);
    @(negedge clk); alu_en = 1'b0; rst_n = 1'b0;
    #1 check("R8 async clear", cc_flags, 0);
    @(negedge clk); rst_n = 1'b1;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule